// File: doc/BRIEF.md
# SPI Clock Profile Generator

This block derives a serial clock and two shift-control strobes from a faster reference clock. Each reference cycle a phase accumulator adds a step taken from a 16-bit frequency word, where 2048 stands for the full reference rate. Every time the running sum reaches 2048 the serial clock changes level, so the serial clock toggles on average `step / 2048` times per reference cycle. The leftover part of the sum is kept, which lets fractional ratios average out exactly. An option drops that leftover instead, which gives a simple integer divider.

The shift logic next to the block uses two one-cycle strobes. The launch strobe marks the serial-clock edge on which new output data is driven. The sample strobe marks the edge on which input data is captured. Each strobe picks its edge, rising or falling, on its own. A polarity input sets the idle level of the serial clock. A double-rate input doubles the step before it is clamped. A mode bit that selects the asynchronous input path is registered and passed on to the capture logic outside this block.

Top module: `sclk_prof_gen`

## Requirements
- R1: While `rst_n` is low, `sclk`, `launch_stb`, `sample_stb` and `async_mode` are all 0.
- R2: In each cycle with `en` high, the effective step is added to the accumulator. When the sum is 2048 or more, `sclk` changes level one cycle later and 2048 is subtracted. Over N enabled cycles that start from a cleared accumulator, `sclk` changes floor(N*step/2048) times.
- R3: When `wrap_clr` is 1, the accumulator is set to 0 on every wrap instead of keeping the remainder. With a step of 768, 48 enabled cycles then give 16 level changes instead of 18.
- R4: A frequency word of 0 keeps `sclk` at its idle level and produces no strobes.
- R5: A step above 2048 is clamped to 2048. `sclk` then changes level every cycle. A word of 2047 gives 39 changes in 40 cycles.
- R6: When `dbl_rate` is 1, the frequency word is doubled before the clamp. For example, 300 behaves like 600.
- R7: `sclk` equals the internal phase XOR `cpol`, registered. The idle level is therefore `cpol` (0 = idle low, 1 = idle high), and the first edge after enable goes away from idle.
- R8: When `en` is 0, the accumulator and phase are cleared. One cycle later `sclk` shows the idle level and both strobes are 0.
- R9: `launch_stb` is high for exactly the cycle in which `sclk` shows a new level. It fires for a rising edge when `launch_rise` is 1 and for a falling edge when it is 0.
- R10: `sample_stb` follows the same rule as R9, with its edge chosen by `latch_rise`. When `launch_rise` equals `latch_rise` the two strobes coincide. When they differ, the two strobes are never high in the same cycle.
- R11: `async_mode` shows `async_req` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Runs the generator. Low clears the generator and idles the clock |
| freq_word | input | 16 | Frequency control word (2048 = full rate) |
| wrap_clr | input | 1 | Clear the accumulator on every wrap |
| dbl_rate | input | 1 | Double the step before clamping |
| launch_rise | input | 1 | Launch strobe on the rising edge (1) or the falling edge (0) |
| latch_rise | input | 1 | Sample strobe on the rising edge (1) or the falling edge (0) |
| cpol | input | 1 | Idle level of the serial clock |
| async_req | input | 1 | Asynchronous input path select, passed through |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle launch strobe |
| sample_stb | output | 1 | One-cycle sample strobe |
| async_mode | output | 1 | Registered asynchronous path select |

## Verification
The generator is run with the following frequency words:
- 512 and 1024 divide evenly, so they check the basic toggle count and the strobe alignment.
- 768 leaves a remainder on each wrap, which separates remainder-keeping from reset-on-loop (18 against 16 changes).
- 2047, 2048 and 5000 check the clamp boundary.
- 300 with and without double rate checks that the doubling happens before the clamp.
- 0 checks the silent case.

The edge selections are tried both split and equal, and under both polarities. This shows whether each strobe follows its own select and whether the idle level and the first edge follow `cpol`. A cycle-accurate model compares all four outputs in every cycle, so a strobe that is off by one cycle or on the wrong edge is also caught.

// File: rtl/sclkgen_pkg.sv
package sclkgen_pkg;

   // Edge selection and idle level for one profile
   typedef struct packed {
      logic launch_rise;
      logic latch_rise;
      logic idle_high;
   } edge_cfg_t;

endpackage

// File: rtl/sclkgen_step.sv
// Effective accumulator step: optional doubling, then clamp to full rate.
module sclkgen_step #(
   parameter int FW_W       = 16,
   parameter int SCALE_LOG2 = 11,
   parameter bit HAS_DBL    = 1'b1
) (
   input  logic [FW_W-1:0]     freq_word,
   input  logic                dbl_rate,
   output logic [SCALE_LOG2:0] step
);
   localparam logic [FW_W:0] FULL_W =
      {{(FW_W-SCALE_LOG2){1'b0}}, 1'b1, {SCALE_LOG2{1'b0}}};

   logic [FW_W:0] scaled;

   generate
      if (HAS_DBL) begin : g_dbl
         assign scaled = dbl_rate ? {freq_word, 1'b0} : {1'b0, freq_word};
      end else begin : g_nodbl
         logic unused_dbl;
         assign unused_dbl = dbl_rate;
         assign scaled     = {1'b0, freq_word};
      end
   endgenerate

   assign step = (scaled > FULL_W) ? FULL_W[SCALE_LOG2:0] : scaled[SCALE_LOG2:0];

endmodule

// File: rtl/sclkgen_acc.sv
// Fractional phase accumulator; tick marks a crossing of the full scale.
module sclkgen_acc #(
   parameter int SCALE_LOG2 = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                wrap_clr,
   input  logic [SCALE_LOG2:0] step,
   output logic                tick
);
   logic [SCALE_LOG2-1:0] acc_q;
   logic [SCALE_LOG2-1:0] acc_d;
   logic [SCALE_LOG2:0]   sum;

   assign sum  = {1'b0, acc_q} + step;
   assign tick = en & sum[SCALE_LOG2];

   always_comb begin
      if (!en)
         acc_d = '0;
      else if (tick && wrap_clr)
         acc_d = '0;
      else
         acc_d = sum[SCALE_LOG2-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

endmodule

// File: rtl/sclkgen_edge.sv
// Phase flop, serial clock level and per-edge strobes.
module sclkgen_edge
   import sclkgen_pkg::*;
#(
   parameter int N_STRB = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  edge_cfg_t        cfg,
   output logic             sclk,
   output logic [N_STRB-1:0] strb
);
   logic              ph_q, ph_d, lvl_d, sclk_q;
   logic [N_STRB-1:0] rise_sel, strb_d, strb_q;

   assign ph_d     = en ? (ph_q ^ tick) : 1'b0;
   assign lvl_d    = ph_d ^ cfg.idle_high;
   assign rise_sel = {cfg.latch_rise, cfg.launch_rise};

   generate
      for (genvar gi = 0; gi < N_STRB; gi++) begin : g_strb
         // fire when the new level matches the selected edge direction
         assign strb_d[gi] = tick & ~(rise_sel[gi] ^ lvl_d);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= 1'b0;
         sclk_q <= 1'b0;
         strb_q <= '0;
      end else begin
         ph_q   <= ph_d;
         sclk_q <= lvl_d;
         strb_q <= strb_d;
      end
   end

   assign sclk = sclk_q;
   assign strb = strb_q;

endmodule

// File: rtl/sclk_prof_gen.sv
module sclk_prof_gen
   import sclkgen_pkg::*;
#(
   parameter int FW_W       = 16,
   parameter int SCALE_LOG2 = 11,
   parameter bit HAS_DBL    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [FW_W-1:0] freq_word,
   input  logic            wrap_clr,
   input  logic            dbl_rate,
   input  logic            launch_rise,
   input  logic            latch_rise,
   input  logic            cpol,
   input  logic            async_req,
   output logic            sclk,
   output logic            launch_stb,
   output logic            sample_stb,
   output logic            async_mode
);
   localparam int STEP_W = SCALE_LOG2 + 1;

   generate
      if (SCALE_LOG2 < 2) begin : g_bad_scale
         $error("SCALE_LOG2 must be at least 2");
      end
      if (FW_W < STEP_W) begin : g_bad_width
         $error("FW_W must hold the full-scale value");
      end
   endgenerate

   logic [STEP_W-1:0] step;
   logic              tick;
   logic [1:0]        strb;
   edge_cfg_t         cfg;
   logic              async_q;

   assign cfg = '{launch_rise: launch_rise, latch_rise: latch_rise, idle_high: cpol};

   sclkgen_step #(.FW_W(FW_W), .SCALE_LOG2(SCALE_LOG2), .HAS_DBL(HAS_DBL)) u_step (
      .freq_word (freq_word),
      .dbl_rate  (dbl_rate),
      .step      (step)
   );

   sclkgen_acc #(.SCALE_LOG2(SCALE_LOG2)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .wrap_clr (wrap_clr),
      .step     (step),
      .tick     (tick)
   );

   sclkgen_edge #(.N_STRB(2)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .tick  (tick),
      .cfg   (cfg),
      .sclk  (sclk),
      .strb  (strb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) async_q <= 1'b0;
      else        async_q <= async_req;
   end

   assign launch_stb = strb[0];
   assign sample_stb = strb[1];
   assign async_mode = async_q;

endmodule

// File: rtl/sclk_prof_gen_chk.sv
module sclk_prof_gen_chk #(
   parameter int FW_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            en,
   input logic [FW_W-1:0] freq_word,
   input logic            launch_rise,
   input logic            latch_rise,
   input logic            cpol,
   input logic            async_req,
   input logic            sclk,
   input logic            launch_stb,
   input logic            sample_stb,
   input logic            async_mode
);
   a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!launch_stb && !sample_stb));

   a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (sclk == $past(cpol)));

   a_r4_zero_word_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (en && freq_word == '0) |=> (!launch_stb && !sample_stb));

   a_r9_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      ((launch_stb || sample_stb) && $past(rst_n) && $past(cpol) == $past(cpol, 2))
      |-> (sclk != $past(sclk)));

   a_r10_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_rise == latch_rise) |=> (launch_stb == sample_stb));

   a_r10_split_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_rise != latch_rise) |=> !(launch_stb && sample_stb));

   a_r11_async_follow: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (async_mode == $past(async_req)));

endmodule

bind sclk_prof_gen sclk_prof_gen_chk #(.FW_W(FW_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .freq_word   (freq_word),
   .launch_rise (launch_rise),
   .latch_rise  (latch_rise),
   .cpol        (cpol),
   .async_req   (async_req),
   .sclk        (sclk),
   .launch_stb  (launch_stb),
   .sample_stb  (sample_stb),
   .async_mode  (async_mode)
);

// File: tb/sclk_prof_gen_test.sv
module sclk_prof_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [15:0] freq_word = '0;
   logic        wrap_clr = 1'b0, dbl_rate = 1'b0;
   logic        launch_rise = 1'b1, latch_rise = 1'b0;
   logic        cpol = 1'b0, async_req = 1'b0;
   logic        sclk, launch_stb, sample_stb, async_mode;

   int    checks = 0, errors = 0;
   int    tog_cnt = 0, lch_cnt = 0, smp_cnt = 0;
   logic  prev_sclk = 1'b0;
   string tag = "R1";
   bit    finished = 0;
   logic [3:0] exp_q[$];

   always #10 clk = ~clk;

   sclk_prof_gen uut (
      .clk(clk), .rst_n(rst_n), .en(en), .freq_word(freq_word),
      .wrap_clr(wrap_clr), .dbl_rate(dbl_rate), .launch_rise(launch_rise),
      .latch_rise(latch_rise), .cpol(cpol), .async_req(async_req),
      .sclk(sclk), .launch_stb(launch_stb), .sample_stb(sample_stb),
      .async_mode(async_mode)
   );

   // Reference model: pushes the expected outputs for every clock edge
   int   m_acc = 0;
   logic m_ph = 1'b0;
   always @(posedge clk) begin
      int   step;
      logic lvl, l_s, s_s;
      if (rst_n) begin
         step = int'(freq_word);
         if (dbl_rate) step = step * 2;
         if (step > 2048) step = 2048;
         l_s = 1'b0;
         s_s = 1'b0;
         if (!en) begin
            m_acc = 0;
            m_ph  = 1'b0;
         end else if (m_acc + step >= 2048) begin
            m_acc = wrap_clr ? 0 : m_acc + step - 2048;
            m_ph  = ~m_ph;
            lvl   = m_ph ^ cpol;
            l_s   = launch_rise ? lvl : ~lvl;
            s_s   = latch_rise ? lvl : ~lvl;
         end else begin
            m_acc = m_acc + step;
         end
         exp_q.push_back({m_ph ^ cpol, l_s, s_s, async_req});
      end
   end

   // Monitor: pops expectations and compares them, counts edges
   always @(negedge clk) begin
      logic [3:0] e, got;
      if (exp_q.size() > 0) begin
         e   = exp_q.pop_front();
         got = {sclk, launch_stb, sample_stb, async_mode};
         checks++;
         if (got !== e) begin
            errors++;
            $display("FAIL %s: outputs got %b expected %b at %0t", tag, got, e, $time);
         end
      end
      if (sclk !== prev_sclk) tog_cnt++;
      if (launch_stb) lch_cnt++;
      if (sample_stb) smp_cnt++;
      prev_sclk = sclk;
   end

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   // enabled window of n cycles starting from a cleared accumulator
   task automatic window(int n);
      en = 1'b1;
      tog_cnt = 0; lch_cnt = 0; smp_cnt = 0;
      cyc(n);
   endtask

   task automatic rest();
      en = 1'b0;
      cyc(3);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      cyc(4);
      tag = "R1";
      chk("R1 sclk in reset", int'(sclk), 0);
      chk("R1 strobes in reset", int'(launch_stb | sample_stb), 0);
      chk("R1 async in reset", int'(async_mode), 0);
      rst_n = 1'b1;
      cyc(3);

      tag = "R2";
      freq_word = 16'd512; launch_rise = 1'b1; latch_rise = 1'b0;
      window(64);
      chk("R2 toggles at 512", tog_cnt, 16);
      chk("R9 launch on rising", lch_cnt, 8);
      chk("R10 sample on falling", smp_cnt, 8);
      rest();

      tag = "R3";
      freq_word = 16'd768; wrap_clr = 1'b0;
      window(48);
      chk("R3 remainder kept", tog_cnt, 18);
      rest();
      wrap_clr = 1'b1;
      window(48);
      chk("R3 reset on loop", tog_cnt, 16);
      rest();
      wrap_clr = 1'b0;

      tag = "R4";
      freq_word = 16'd0;
      window(40);
      chk("R4 no toggles", tog_cnt, 0);
      chk("R4 no strobes", lch_cnt + smp_cnt, 0);
      chk("R4 idle level", int'(sclk), 0);
      rest();

      tag = "R5";
      freq_word = 16'd5000;
      window(40);
      chk("R5 clamp above full", tog_cnt, 40);
      rest();
      freq_word = 16'd2048;
      window(40);
      chk("R5 full rate", tog_cnt, 40);
      rest();
      freq_word = 16'd2047;
      window(40);
      chk("R5 just below full", tog_cnt, 39);
      rest();

      tag = "R6";
      freq_word = 16'd300; dbl_rate = 1'b0;
      window(64);
      chk("R6 single rate", tog_cnt, 9);
      rest();
      dbl_rate = 1'b1;
      window(64);
      chk("R6 double rate", tog_cnt, 18);
      rest();
      freq_word = 16'd1500;
      window(40);
      chk("R6 doubled then clamped", tog_cnt, 40);
      rest();
      dbl_rate = 1'b0;

      tag = "R7";
      cpol = 1'b1;
      cyc(2);
      chk("R7 idle high", int'(sclk), 1);
      freq_word = 16'd1024;
      en = 1'b1;
      cyc(2);
      chk("R7 first edge leaves idle", int'(sclk), 0);
      rest();
      window(64);
      chk("R7 toggles inverted", tog_cnt, 32);
      chk("R9 launch rising inverted", lch_cnt, 16);
      rest();
      cpol = 1'b0;

      tag = "R10";
      freq_word = 16'd1024; launch_rise = 1'b1; latch_rise = 1'b1;
      window(64);
      chk("R10 same edge launch", lch_cnt, 16);
      chk("R10 same edge sample", smp_cnt, 16);
      launch_rise = 1'b0; latch_rise = 1'b0;
      window(64);
      chk("R9 launch falling", lch_cnt, 16);
      rest();

      tag = "R8";
      freq_word = 16'd2048;
      window(10);
      en = 1'b0;
      tog_cnt = 0; lch_cnt = 0; smp_cnt = 0;
      cyc(1);
      chk("R8 idle after disable", int'(sclk), 0);
      cyc(20);
      chk("R8 strobes suppressed", lch_cnt + smp_cnt, 0);

      tag = "R11";
      async_req = 1'b1;
      cyc(1);
      chk("R11 async follows", int'(async_mode), 1);
      async_req = 1'b0;
      cyc(1);
      chk("R11 async clears", int'(async_mode), 0);

      cyc(3);
      finish_run();
   end
endmodule